// File: doc/BRIEF.md
# Serial Audio Link Register Command Decoder

This block listens to the controller-to-codec serial stream of an audio codec link and decides, once per frame, whether that frame's register command is meant for this codec. It counts bits from the frame sync. It collects the 16-bit tag slot, the 20-bit command address slot and the 20-bit command data slot. It then issues a single-cycle read or write strobe, together with the 7-bit register index and the 16-bit write data.

A 2-bit strap sets the device role. Strap 00 is the primary device, which qualifies commands with the frame-valid, address-valid and data-valid tag bits. Straps 01, 10 and 11 are secondary devices. A secondary device ignores the two per-slot command tags and accepts a command when the 2-bit ID at the bottom of the tag slot equals its strap, provided the frame-valid bit is set.

The block also handles a test mode. If the controller's serial line is high at the clock where reset is released, the codec's bit-clock and serial-return outputs go to high impedance. They stay that way until a later reset during which both the sync and serial lines are held low.

Top module: `aclink_cmd_decoder`

## Requirements
- R1: After reset both strobes are low, the register index and write data outputs are zero, and outside test mode `bclk_o` and `sdin_o` follow `bclk_src_i` and `sdin_src_i`.
- R2: With strap 00, a frame whose tag has bit 15 (frame valid), bit 14 (address valid) and bit 13 (data valid) set and bits 1:0 equal to 00 produces a write strobe when address bit 19 is 0.
- R3: With strap 00, no strobe is produced when the tag ID bits 1:0 are non-zero, or when tag bit 14 is clear. A write also needs tag bit 13.
- R4: With a non-zero strap, a frame with tag bit 15 set and tag bits 1:0 equal to the strap is accepted, whatever tag bits 14 and 13 hold.
- R5: With a non-zero strap, a frame whose tag ID differs from the strap, including ID 00, produces no strobe.
- R6: A frame with tag bit 15 clear produces no strobe, for any strap and any ID.
- R7: Address bit 19 set selects a read. A read needs only a valid address. Read and write strobes are never high together.
- R8: A strobe is high for exactly one clock. It is visible at the 57th sampling edge after the edge at which sync was first seen high; the bits of a frame are sampled on the 56 edges that follow that edge.
- R9: The register index is command address bits 18:12. The write data is command data bits 19:4. Both are presented with the strobe.
- R10: If `ser_i` is high at the first clock edge with `rst_n` high after a reset, `bclk_o` and `sdin_o` are released to high impedance.
- R11: Test mode persists through a reset during which `ser_i` or `sync_i` is high. It is cleared only by a reset clock edge at which both are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock (bit-clock sampling edge) |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| sync_i | input | 1 | Frame sync from controller |
| ser_i | input | 1 | Controller-to-codec serial data, MSB first |
| strap_id_i | input | 2 | Device role: 00 primary, else secondary ID |
| bclk_src_i | input | 1 | Bit clock value the codec would drive |
| sdin_src_i | input | 1 | Return serial value the codec would drive |
| bclk_o | output | 1 | Bit clock pad, high impedance in test mode |
| sdin_o | output | 1 | Return serial pad, high impedance in test mode |
| rd_stb_o | output | 1 | One-cycle register read strobe |
| wr_stb_o | output | 1 | One-cycle register write strobe |
| reg_idx_o | output | 7 | Register index for the strobe |
| reg_wdata_o | output | 16 | Write data for the strobe |

## Verification
The assertions assume that sync rises no more than once every 57 clocks and that the strap does not change while a frame is in flight. They also assume that reset is released away from the sampling edge. The stimulus starts every frame with a one-clock sync lead after a long low gap. It changes the strap only between frames, and it moves `rst_n` only on the falling clock edge. The test-mode checks drive the pad sources high, so a released pad is seen as not high, whichever way the simulator resolves high impedance.

// File: rtl/acd_pkg.sv
package acd_pkg;
  localparam int TAG_BITS   = 16;
  localparam int SLOT_BITS  = 20;
  localparam int FRAME_LEN  = 256;
  localparam int IDX_BITS   = 7;
  localparam int WDATA_BITS = 16;
  localparam int ID_BITS    = 2;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_TAG,
    PH_ADDR,
    PH_DATA,
    PH_DONE
  } phase_e;
endpackage

// File: rtl/acd_frame_timer.sv
module acd_frame_timer
  import acd_pkg::*;
#(
  parameter int FRAME_BITS = FRAME_LEN,
  parameter int TAG_W      = TAG_BITS,
  parameter int SLOT_W     = SLOT_BITS
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   sync_i,
  output phase_e phase_o
);
  localparam int CNT_W    = $clog2(FRAME_BITS);
  localparam int ADDR_END = TAG_W + SLOT_W;
  localparam int DATA_END = ADDR_END + SLOT_W;

  logic             sync_q;
  logic             active_q, active_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             start;

  assign start = sync_i & ~sync_q;

  always_comb begin
    cnt_d    = cnt_q;
    active_d = active_q;
    if (start) begin
      cnt_d    = '0;
      active_d = 1'b1;
    end else if (active_q) begin
      cnt_d = (cnt_q == CNT_W'(FRAME_BITS - 1)) ? '0 : cnt_q + 1'b1;
    end
  end

  always_comb begin
    if (!active_q || start)            phase_o = PH_IDLE;
    else if (int'(cnt_q) < TAG_W)      phase_o = PH_TAG;
    else if (int'(cnt_q) < ADDR_END)   phase_o = PH_ADDR;
    else if (int'(cnt_q) < DATA_END)   phase_o = PH_DATA;
    else if (int'(cnt_q) == DATA_END)  phase_o = PH_DONE;
    else                               phase_o = PH_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q   <= 1'b0;
      active_q <= 1'b0;
      cnt_q    <= '0;
    end else begin
      sync_q   <= sync_i;
      active_q <= active_d;
      cnt_q    <= cnt_d;
    end
  end

  // Decision point lasts a single cycle per frame
  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_o == PH_DONE) |=> (phase_o != PH_DONE));
endmodule

// File: rtl/acd_slot_capture.sv
module acd_slot_capture
  import acd_pkg::*;
#(
  parameter int TAG_W  = TAG_BITS,
  parameter int SLOT_W = SLOT_BITS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  phase_e            phase_i,
  input  logic              ser_i,
  output logic [TAG_W-1:0]  tag_q,
  output logic [SLOT_W-1:0] addr_q,
  output logic [SLOT_W-1:0] data_q
);
  logic tag_en, addr_en, data_en;

  assign tag_en  = (phase_i == PH_TAG);
  assign addr_en = (phase_i == PH_ADDR);
  assign data_en = (phase_i == PH_DATA);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tag_q  <= '0;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      if (tag_en)  tag_q  <= {tag_q[TAG_W-2:0], ser_i};
      if (addr_en) addr_q <= {addr_q[SLOT_W-2:0], ser_i};
      if (data_en) data_q <= {data_q[SLOT_W-2:0], ser_i};
    end
  end

  // Captured fields hold outside their own slot window
  assert_tag_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_i != PH_TAG) |=> $stable(tag_q));
  assert_addr_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_i != PH_ADDR) |=> $stable(addr_q));
endmodule

// File: rtl/acd_accept.sv
module acd_accept
  import acd_pkg::*;
#(
  parameter int TAG_W  = TAG_BITS,
  parameter int SLOT_W = SLOT_BITS,
  parameter int IDX_W  = IDX_BITS,
  parameter int DATA_W = WDATA_BITS,
  parameter int ID_W   = ID_BITS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ID_W-1:0]   strap_i,
  input  phase_e            phase_i,
  input  logic [TAG_W-1:0]  tag_i,
  input  logic [SLOT_W-1:0] addr_i,
  input  logic [SLOT_W-1:0] data_i,
  output logic              rd_stb_o,
  output logic              wr_stb_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic [DATA_W-1:0] wdata_o
);
  localparam int FV_BIT = TAG_W - 1;
  localparam int AV_BIT = TAG_W - 2;
  localparam int DV_BIT = TAG_W - 3;
  localparam int RW_BIT = SLOT_W - 1;

  logic            frame_ok, id_hit, is_primary;
  logic            addr_ok, data_ok, decide;
  logic            rd_d, wr_d;
  logic [IDX_W-1:0]  idx_d;
  logic [DATA_W-1:0] wdata_d;

  assign is_primary = (strap_i == '0);
  assign frame_ok   = tag_i[FV_BIT];
  assign id_hit     = (tag_i[ID_W-1:0] == strap_i);
  assign decide     = (phase_i == PH_DONE);

  always_comb begin
    if (is_primary) begin
      addr_ok = frame_ok & id_hit & tag_i[AV_BIT];
      data_ok = frame_ok & id_hit & tag_i[DV_BIT];
    end else begin
      addr_ok = frame_ok & id_hit;
      data_ok = frame_ok & id_hit;
    end
  end

  always_comb begin
    rd_d    = decide & addr_ok & addr_i[RW_BIT];
    wr_d    = decide & addr_ok & data_ok & ~addr_i[RW_BIT];
    idx_d   = idx_o;
    wdata_d = wdata_o;
    if (rd_d || wr_d) begin
      idx_d   = addr_i[RW_BIT-1 -: IDX_W];
      wdata_d = data_i[SLOT_W-1 -: DATA_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_stb_o <= 1'b0;
      wr_stb_o <= 1'b0;
      idx_o    <= '0;
      wdata_o  <= '0;
    end else begin
      rd_stb_o <= rd_d;
      wr_stb_o <= wr_d;
      idx_o    <= idx_d;
      wdata_o  <= wdata_d;
    end
  end

  assert_no_dual_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_stb_o && wr_stb_o));
  assert_rd_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb_o |=> !rd_stb_o);
  assert_wr_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb_o |=> !wr_stb_o);
  assert_needs_frame_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb_o || wr_stb_o) |-> tag_i[FV_BIT]);
  assert_secondary_id_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((strap_i != '0) && (rd_stb_o || wr_stb_o)) |-> (tag_i[ID_W-1:0] == strap_i));
  assert_primary_tags_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((strap_i == '0) && (rd_stb_o || wr_stb_o)) |-> (tag_i[AV_BIT] && tag_i[ID_W-1:0] == '0));
endmodule

// File: rtl/acd_test_ctrl.sv
module acd_test_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic sync_i,
  input  logic ser_i,
  input  logic bclk_src_i,
  input  logic sdin_src_i,
  output wire  bclk_o,
  output wire  sdin_o
);
  logic rst_prev_q;
  logic test_q, test_d;

  always_comb begin
    test_d = test_q;
    if (!rst_n) begin
      if (!sync_i && !ser_i) test_d = 1'b0;
    end else if (!rst_prev_q) begin
      test_d = test_q | ser_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_prev_q <= 1'b0;
    else        rst_prev_q <= 1'b1;
  end

  // Deliberately outside the asynchronous reset: it must survive a reset
  always_ff @(posedge clk) begin
    test_q <= test_d;
  end

  assign bclk_o = test_q ? 1'bz : bclk_src_i;
  assign sdin_o = test_q ? 1'bz : sdin_src_i;

  assert_entry_on_high_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (test_q && !$past(test_q)) |-> $past(ser_i));
  assert_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    test_q |=> test_q);
endmodule

// File: rtl/aclink_cmd_decoder.sv
module aclink_cmd_decoder
  import acd_pkg::*;
#(
  parameter int FRAME_BITS = FRAME_LEN,
  parameter int TAG_W      = TAG_BITS,
  parameter int SLOT_W     = SLOT_BITS,
  parameter int IDX_W      = IDX_BITS,
  parameter int DATA_W     = WDATA_BITS,
  parameter int ID_W       = ID_BITS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sync_i,
  input  logic              ser_i,
  input  logic [ID_W-1:0]   strap_id_i,
  input  logic              bclk_src_i,
  input  logic              sdin_src_i,
  output wire               bclk_o,
  output wire               sdin_o,
  output logic              rd_stb_o,
  output logic              wr_stb_o,
  output logic [IDX_W-1:0]  reg_idx_o,
  output logic [DATA_W-1:0] reg_wdata_o
);
  phase_e            phase;
  logic [TAG_W-1:0]  tag_q;
  logic [SLOT_W-1:0] addr_q, data_q;

  acd_frame_timer #(.FRAME_BITS(FRAME_BITS), .TAG_W(TAG_W), .SLOT_W(SLOT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .sync_i(sync_i), .phase_o(phase)
  );

  acd_slot_capture #(.TAG_W(TAG_W), .SLOT_W(SLOT_W)) u_capture (
    .clk(clk), .rst_n(rst_n), .phase_i(phase), .ser_i(ser_i),
    .tag_q(tag_q), .addr_q(addr_q), .data_q(data_q)
  );

  acd_accept #(.TAG_W(TAG_W), .SLOT_W(SLOT_W), .IDX_W(IDX_W), .DATA_W(DATA_W),
               .ID_W(ID_W)) u_accept (
    .clk(clk), .rst_n(rst_n), .strap_i(strap_id_i), .phase_i(phase),
    .tag_i(tag_q), .addr_i(addr_q), .data_i(data_q),
    .rd_stb_o(rd_stb_o), .wr_stb_o(wr_stb_o), .idx_o(reg_idx_o), .wdata_o(reg_wdata_o)
  );

  acd_test_ctrl u_test (
    .clk(clk), .rst_n(rst_n), .sync_i(sync_i), .ser_i(ser_i),
    .bclk_src_i(bclk_src_i), .sdin_src_i(sdin_src_i),
    .bclk_o(bclk_o), .sdin_o(sdin_o)
  );
endmodule

// File: tb/aclink_cmd_decoder_bench.sv
module aclink_cmd_decoder_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sync_i = 1'b0;
  logic        ser_i = 1'b0;
  logic [1:0]  strap_id_i = 2'd0;
  logic        bclk_src_i = 1'b1;
  logic        sdin_src_i = 1'b1;
  wire         bclk_o, sdin_o;
  logic        rd_stb_o, wr_stb_o;
  logic [6:0]  reg_idx_o;
  logic [15:0] reg_wdata_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  aclink_cmd_decoder u_aclink_cmd_decoder (
    .clk(clk), .rst_n(rst_n), .sync_i(sync_i), .ser_i(ser_i), .strap_id_i(strap_id_i),
    .bclk_src_i(bclk_src_i), .sdin_src_i(sdin_src_i), .bclk_o(bclk_o), .sdin_o(sdin_o),
    .rd_stb_o(rd_stb_o), .wr_stb_o(wr_stb_o), .reg_idx_o(reg_idx_o), .reg_wdata_o(reg_wdata_o)
  );

  typedef struct packed {
    logic [1:0]  strap;
    logic [15:0] tag;
    logic [19:0] addr;
    logic [19:0] data;
    logic        exp_rd;
    logic        exp_wr;
    logic [6:0]  exp_idx;
    logic [15:0] exp_wdata;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 16'hE000, 20'h05FFF, 20'hABCDF, 1'b0, 1'b1, 7'h05, 16'hABCD}, // R2 R9
    '{2'd0, 16'hC000, 20'h05000, 20'h11110, 1'b0, 1'b0, 7'h00, 16'h0000}, // R3 no data tag
    '{2'd0, 16'hC000, 20'h83000, 20'h00000, 1'b1, 1'b0, 7'h03, 16'h0000}, // R7 read
    '{2'd0, 16'hE001, 20'h05000, 20'h22220, 1'b0, 1'b0, 7'h00, 16'h0000}, // R3 id
    '{2'd0, 16'hA000, 20'h05000, 20'h33330, 1'b0, 1'b0, 7'h00, 16'h0000}, // R3 no addr tag
    '{2'd1, 16'h8001, 20'h7F000, 20'h12345, 1'b0, 1'b1, 7'h7F, 16'h1234}, // R4
    '{2'd2, 16'h8001, 20'h7F000, 20'h12345, 1'b0, 1'b0, 7'h00, 16'h0000}, // R5
    '{2'd2, 16'h8002, 20'h81000, 20'h00000, 1'b1, 1'b0, 7'h01, 16'h0000}, // R4 read
    '{2'd3, 16'h0003, 20'h2A000, 20'h55AA0, 1'b0, 1'b0, 7'h00, 16'h0000}, // R6
    '{2'd3, 16'hE003, 20'h2A000, 20'h55AA0, 1'b0, 1'b1, 7'h2A, 16'h55AA}, // R4 tags ignored
    '{2'd1, 16'h8000, 20'h05000, 20'h44440, 1'b0, 1'b0, 7'h00, 16'h0000}, // R5 id 00
    '{2'd0, 16'h6000, 20'h05000, 20'h66660, 1'b0, 1'b0, 7'h00, 16'h0000}  // R6 primary
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send_frame(input logic [15:0] tag, input logic [19:0] addr,
                            input logic [19:0] data);
    logic [55:0] bits;
    bits = {tag, addr, data};
    @(negedge clk);
    sync_i = 1'b1;
    ser_i  = 1'b0;
    for (int i = 0; i < 56; i++) begin
      @(negedge clk);
      ser_i = bits[55-i];
      if (i == 15) sync_i = 1'b0;
    end
  endtask

  task automatic run_vec(input vec_t v);
    int rd_n, wr_n, rd_at, wr_at;
    logic [6:0]  idx_seen;
    logic [15:0] wd_seen;
    rd_n = 0; wr_n = 0; rd_at = -1; wr_at = -1;
    idx_seen = '0; wd_seen = '0;
    strap_id_i = v.strap;
    send_frame(v.tag, v.addr, v.data);
    for (int j = 0; j < 10; j++) begin
      @(negedge clk);
      ser_i = 1'b0;
      if (rd_stb_o) begin rd_n++; rd_at = j; idx_seen = reg_idx_o; end
      if (wr_stb_o) begin wr_n++; wr_at = j; idx_seen = reg_idx_o; wd_seen = reg_wdata_o; end
    end
    check(rd_n == int'(v.exp_rd), "R7 read strobe count", rd_n, int'(v.exp_rd));
    check(wr_n == int'(v.exp_wr), "R2 R4 R5 R6 write strobe count", wr_n, int'(v.exp_wr));
    if (v.exp_rd) begin
      check(rd_at == 1, "R8 read strobe cycle", rd_at, 1);
      check(idx_seen == v.exp_idx, "R9 read index", int'(idx_seen), int'(v.exp_idx));
    end
    if (v.exp_wr) begin
      check(wr_at == 1, "R8 write strobe cycle", wr_at, 1);
      check(idx_seen == v.exp_idx, "R9 write index", int'(idx_seen), int'(v.exp_idx));
      check(wd_seen == v.exp_wdata, "R9 write data", int'(wd_seen), int'(v.exp_wdata));
    end
    repeat (20) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(!rd_stb_o && !wr_stb_o, "R1 strobes idle", int'({rd_stb_o, wr_stb_o}), 0);
    check(reg_idx_o == '0, "R1 index zero", int'(reg_idx_o), 0);
    check(reg_wdata_o == '0, "R1 data zero", int'(reg_wdata_o), 0);
    check(bclk_o === 1'b1 && sdin_o === 1'b1, "R1 pads driven high", int'({bclk_o, sdin_o}), 3);
    bclk_src_i = 1'b0; sdin_src_i = 1'b1;
    @(negedge clk);
    check(bclk_o === 1'b0 && sdin_o === 1'b1, "R1 pads follow sources", int'({bclk_o, sdin_o}), 1);
    bclk_src_i = 1'b1;

    for (int k = 0; k < NV; k++) run_vec(VECS[k]);

    // R8: two accepted frames back to back each give one pulse
    run_vec(VECS[0]);
    run_vec(VECS[5]);

    // R10: enter test mode with ser high at reset release
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    ser_i = 1'b1;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    ser_i = 1'b0;
    @(negedge clk);
    check(bclk_o !== 1'b1, "R10 bit clock released", int'(bclk_o), 0);
    check(sdin_o !== 1'b1, "R10 return line released", int'(sdin_o), 0);

    // R11: reset with ser high throughout keeps test mode
    rst_n = 1'b0;
    ser_i = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    ser_i = 1'b0;
    repeat (2) @(negedge clk);
    check(bclk_o !== 1'b1, "R11 test mode kept after busy reset", int'(bclk_o), 0);

    // R11: reset with sync high throughout keeps test mode
    rst_n = 1'b0;
    sync_i = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    sync_i = 1'b0;
    repeat (2) @(negedge clk);
    check(sdin_o !== 1'b1, "R11 test mode kept after sync-high reset", int'(sdin_o), 0);

    // R11: reset with all lines low exits test mode
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(bclk_o === 1'b1, "R11 bit clock driven again", int'(bclk_o), 1);
    check(sdin_o === 1'b1, "R11 return line driven again", int'(sdin_o), 1);

    // R2 decoding works after leaving test mode
    run_vec(VECS[0]);

    finish_run();
  end
endmodule